// File: doc/BRIEF.md
# Host Command Packet Packer

This block turns one host command (a virtual channel, a data type, a payload length, request flags and a stream of payload bytes) into the 32-bit words that a serial display link controller loads into its transmit queue. The first word is a packet header. It carries the data type and the channel, and up to the first two payload bytes. Every later payload byte is packed four to a word, with the lowest byte in the lowest lane, and the last word is padded with zeros.

The block also decides where and how the packet goes. A packet that fits in the small command queue goes there, and a longer one goes to the larger pixel queue. A packet too long for either queue is refused. No byte is taken and no word is produced for it. A bus turnaround is requested when the host expects a reply, and a low-power request turns off high-speed transmission. When the packet is finished, a single-cycle completion pulse reports the queue choice, the turnaround and speed flags, an error flag and the count of transmitted bytes.

The command is taken with a valid/ready handshake. Payload bytes arrive on a second valid/ready stream, and words leave on a third. The block handles one command at a time.

Top module: `hcp_packer`

## Requirements
- R1: The first word of every accepted packet is the header. Bits [5:0] carry the data type, bits [7:6] carry the virtual channel, and bits [31:24] are zero. The header is emitted even when the payload length is 0.
- R2: Payload byte 0 occupies header bits [15:8] and payload byte 1 occupies header bits [23:16]. A header lane with no payload byte behind it reads zero.
- R3: Payload bytes from index 2 onward fill words of four, with the lowest index in bits [7:0] and rising by 8 bits per byte. Lanes past the last byte are zero. A packet of length L has 1 + ceil(max(L-2,0)/4) words.
- R4: When the length exceeds 4*HOST_DEPTH bytes, the packet is routed to the pixel queue: word_to_video is 1 on every word and done_video is 1. Otherwise both are 0.
- R5: When the length exceeds 4*VIDEO_DEPTH bytes, the command is refused. No payload byte is consumed, no word is emitted, and done pulses in the cycle after acceptance with done_err=1 and done_count=0.
- R6: done_bta is 1 exactly when cmd_ack_req is 1 or cmd_rx_len is nonzero.
- R7: done_count is 4 plus the payload length for an accepted packet with no turnaround. It is 0 when a turnaround is requested or the command is refused.
- R8: done_hs is the inverse of cmd_lp.
- R9: A word held with word_valid=1 and word_ready=0 stays valid and unchanged in the next cycle. done is a one-cycle pulse, raised in the cycle after the last word's handshake. cmd_ready is 1 only while no packet is in progress.
- R10: After reset, cmd_ready is 1 and word_valid, byte_ready and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_vc | input | 2 | Virtual channel |
| cmd_dtype | input | 6 | Packet data type |
| cmd_len | input | LEN_W | Payload length in bytes |
| cmd_ack_req | input | 1 | Host requests an acknowledge |
| cmd_rx_len | input | LEN_W | Read buffer size, nonzero for reads |
| cmd_lp | input | 1 | Send in low-power mode |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte taken when valid |
| byte_data | input | 8 | Payload byte |
| word_valid | output | 1 | Queue word offered |
| word_ready | input | 1 | Queue word taken when valid |
| word_data | output | 32 | Queue word |
| word_to_video | output | 1 | Word targets the pixel queue |
| done | output | 1 | Packet finished pulse |
| done_err | output | 1 | Command refused as over-length |
| done_video | output | 1 | Pixel queue was selected |
| done_bta | output | 1 | Turnaround requested after packet |
| done_hs | output | 1 | High-speed transmission selected |
| done_count | output | CNT_W | Transmitted byte count |

## Verification
The assertions take for granted that the byte producer offers exactly cmd_len bytes for an accepted command and none for a refused one. They also take for granted that the word sink eventually raises word_ready. The bench keeps to this: its producer counts bytes against the length it issued and never offers bytes when the length exceeds the pixel queue limit. Irregular gaps in byte_valid and stalls on word_ready still exercise the hold rule. Each command is offered for one cycle while cmd_ready is high, so the command fields only have to be valid at acceptance.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } hcp_state_e;

  // Bytes that ride in the header word: at most two.
  function automatic logic [2:0] take_hdr(input logic [31:0] len);
    return (len >= 32'd2) ? 3'd2 : len[2:0];
  endfunction

  // Bytes that go into one body word: at most four.
  function automatic logic [2:0] take_body(input logic [31:0] rem);
    return (rem >= 32'd4) ? 3'd4 : rem[2:0];
  endfunction

  // Bytes on the wire for a write: four header bytes plus payload.
  function automatic logic [31:0] sent_count(input logic [31:0] len);
    return len + 32'd4;
  endfunction

endpackage

// File: rtl/hcp_cmd_check.sv
module hcp_cmd_check #(
  parameter int HOST_LIMIT  = 256,
  parameter int VIDEO_LIMIT = 1024,
  parameter int LEN_W       = 12
) (
  input  logic [LEN_W-1:0] len,
  input  logic             ack_req,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             lp,
  output logic             over_len,
  output logic             use_video,
  output logic             want_bta,
  output logic             use_hs
);

  always_comb begin
    over_len  = (len > LEN_W'(VIDEO_LIMIT));
    use_video = (len > LEN_W'(HOST_LIMIT));
    want_bta  = ack_req || (rx_len != '0);
    use_hs    = !lp;
  end

endmodule

// File: rtl/hcp_word_asm.sv
module hcp_word_asm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_hdr,
  input  logic        load_data,
  input  logic [7:0]  hdr_byte,
  input  logic        byte_fire,
  input  logic [7:0]  byte_in,
  input  logic        emitting,
  output logic [31:0] word_out,
  output logic [2:0]  fill_out
);

  logic [31:0] word_q;
  logic [2:0]  fill_q;
  logic        is_hdr_q;
  logic [1:0]  lane;

  // Header bytes start one lane up, past the type/channel byte.
  assign lane = is_hdr_q ? (fill_q[1:0] + 2'd1) : fill_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      fill_q   <= '0;
      is_hdr_q <= 1'b0;
    end else if (load_hdr) begin
      word_q   <= {24'h0, hdr_byte};
      fill_q   <= '0;
      is_hdr_q <= 1'b1;
    end else if (load_data) begin
      word_q   <= '0;
      fill_q   <= '0;
      is_hdr_q <= 1'b0;
    end else if (byte_fire) begin
      word_q[{lane, 3'b000} +: 8] <= byte_in;
      fill_q <= fill_q + 3'd1;
    end
  end

  assign word_out = word_q;
  assign fill_out = fill_q;

  // Header top lane is never written.
  p_hdr_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (emitting && is_hdr_q) |-> (word_q[31:24] == 8'h00));

  // Body lanes beyond the bytes taken read zero.
  for (genvar k = 0; k < 4; k++) begin : g_pad
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (emitting && !is_hdr_q && (fill_q <= 3'(k))) |-> (word_q[k*8 +: 8] == 8'h00));
  end

endmodule

// File: rtl/hcp_packer.sv
module hcp_packer #(
  parameter int HOST_DEPTH  = 64,
  parameter int VIDEO_DEPTH = 256,
  localparam int HOST_LIMIT  = 4 * HOST_DEPTH,
  localparam int VIDEO_LIMIT = 4 * VIDEO_DEPTH,
  localparam int LEN_W       = $clog2(VIDEO_LIMIT + 1) + 1,
  localparam int CNT_W       = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_vc,
  input  logic [5:0]       cmd_dtype,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_ack_req,
  input  logic [LEN_W-1:0] cmd_rx_len,
  input  logic             cmd_lp,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [7:0]       byte_data,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic             word_to_video,
  output logic             done,
  output logic             done_err,
  output logic             done_video,
  output logic             done_bta,
  output logic             done_hs,
  output logic [CNT_W-1:0] done_count
);
  import hcp_pkg::*;

  hcp_state_e       state_q;
  logic [LEN_W-1:0] len_q, rem_q, rem_next;
  logic             err_q, video_q, bta_q, hs_q, hdr_phase_q;
  logic             over_len, use_video, want_bta, use_hs;
  logic [2:0]       need, fill;
  logic             cmd_fire, byte_fire, word_fire;
  logic             fill_full, last_word, load_hdr, load_data, emitting;

  hcp_cmd_check #(
    .HOST_LIMIT (HOST_LIMIT),
    .VIDEO_LIMIT(VIDEO_LIMIT),
    .LEN_W      (LEN_W)
  ) u_check (
    .len      (cmd_len),
    .ack_req  (cmd_ack_req),
    .rx_len   (cmd_rx_len),
    .lp       (cmd_lp),
    .over_len (over_len),
    .use_video(use_video),
    .want_bta (want_bta),
    .use_hs   (use_hs)
  );

  // Handshake events and phase decisions as named wires.
  assign cmd_ready  = (state_q == ST_IDLE);
  assign emitting   = (state_q == ST_EMIT);
  assign word_valid = emitting;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign need       = hdr_phase_q ? take_hdr(32'(rem_q)) : take_body(32'(rem_q));
  assign fill_full  = (fill == need);
  assign byte_ready = (state_q == ST_FILL) && !fill_full;
  assign byte_fire  = byte_valid && byte_ready;
  assign word_fire  = word_valid && word_ready;
  assign rem_next   = rem_q - LEN_W'(need);
  assign last_word  = (rem_next == '0);
  assign load_hdr   = cmd_fire && !over_len;
  assign load_data  = word_fire && !last_word;

  hcp_word_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_hdr (load_hdr),
    .load_data(load_data),
    .hdr_byte ({cmd_vc, cmd_dtype}),
    .byte_fire(byte_fire),
    .byte_in  (byte_data),
    .emitting (emitting),
    .word_out (word_data),
    .fill_out (fill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      rem_q       <= '0;
      err_q       <= 1'b0;
      video_q     <= 1'b0;
      bta_q       <= 1'b0;
      hs_q        <= 1'b0;
      hdr_phase_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_fire) begin
          len_q       <= cmd_len;
          rem_q       <= cmd_len;
          err_q       <= over_len;
          video_q     <= use_video;
          bta_q       <= want_bta;
          hs_q        <= use_hs;
          hdr_phase_q <= 1'b1;
          state_q     <= over_len ? ST_DONE : ST_FILL;
        end
        ST_FILL: if (fill_full) state_q <= ST_EMIT;
        ST_EMIT: if (word_fire) begin
          rem_q       <= rem_next;
          hdr_phase_q <= 1'b0;
          state_q     <= last_word ? ST_DONE : ST_FILL;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_to_video = video_q;
  assign done          = (state_q == ST_DONE);
  assign done_err      = err_q;
  assign done_video    = video_q;
  assign done_bta      = bta_q;
  assign done_hs       = hs_q;
  assign done_count    = (err_q || bta_q) ? '0 : CNT_W'(sent_count(32'(len_q)));

  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!word_valid && !byte_ready));

  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!word_valid && !byte_ready));

  p_video_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && (len_q > LEN_W'(HOST_LIMIT))) |-> word_to_video);

  p_bta_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_bta) |-> (done_count == '0));

endmodule

// File: tb/hcp_packer_bench.sv
module hcp_packer_bench;
  localparam int HD = 4;
  localparam int VD = 8;
  localparam int HL = 4 * HD;
  localparam int VL = 4 * VD;
  localparam int LW = $clog2(VL + 1) + 1;
  localparam int CW = LW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_vc = '0;
  logic [5:0] cmd_dtype = '0;
  logic [LW-1:0] cmd_len = '0, cmd_rx_len = '0;
  logic cmd_ack_req = 1'b0, cmd_lp = 1'b0;
  logic byte_valid = 1'b0, byte_ready;
  logic [7:0] byte_data = '0;
  logic word_valid, word_ready = 1'b0, word_to_video;
  logic [31:0] word_data;
  logic done, done_err, done_video, done_bta, done_hs;
  logic [CW-1:0] done_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  hcp_packer #(.HOST_DEPTH(HD), .VIDEO_DEPTH(VD)) u_hcp_packer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vc(cmd_vc),
    .cmd_dtype(cmd_dtype), .cmd_len(cmd_len), .cmd_ack_req(cmd_ack_req),
    .cmd_rx_len(cmd_rx_len), .cmd_lp(cmd_lp),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .word_to_video(word_to_video), .done(done), .done_err(done_err),
    .done_video(done_video), .done_bta(done_bta), .done_hs(done_hs),
    .done_count(done_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'((i * 37 + len * 11 + 5) & 255);
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int len,
                                           input logic [1:0] vc, input logic [5:0] dt);
    logic [31:0] w = '0;
    if (k == 0) begin
      w[7:0] = {vc, dt};
      if (len > 0) w[15:8]  = pat(0, len);
      if (len > 1) w[23:16] = pat(1, len);
    end else begin
      for (int j = 0; j < 4; j++) begin
        int idx = 2 + 4 * (k - 1) + j;
        if (idx < len) w[j*8 +: 8] = pat(idx, len);
      end
    end
    return w;
  endfunction

  task automatic run_case(input int len);
    logic [1:0] vc = 2'(len % 4);
    logic [5:0] dt = 6'((len * 7 + 3) % 64);
    bit ack = (len % 3) == 1;
    int rxl = ((len % 5) == 2) ? 3 : 0;
    bit lp = (len % 2) == 1;
    bit e_err = len > VL;
    bit e_vid = len > HL;
    bit e_bta = ack || (rxl != 0);
    int e_cnt = (e_err || e_bta) ? 0 : 4 + len;
    int e_n = e_err ? 0 : 1 + ((len > 2) ? (len - 2 + 3) / 4 : 0);
    logic [31:0] got [0:15];
    int bi = 0, wc = 0, last_fire = -1, done_cyc = -1;
    bit held_v = 0, route_ok = 1, d_err = 0, d_vid = 0, d_bta = 0, d_hs = 0;
    logic [31:0] held = '0;
    logic [CW-1:0] d_cnt = '0;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_vc = vc; cmd_dtype = dt; cmd_len = LW'(len);
    cmd_ack_req = ack; cmd_rx_len = LW'(rxl); cmd_lp = lp;
    #1;
    chk(cmd_ready, "R9", "cmd_ready idle", 32'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      byte_valid = (bi < len) && !e_err && (((cyc * 5 + len) % 4) != 0);
      byte_data = pat(bi, len);
      word_ready = ((cyc + len) % 3) != 0;
      #1;
      if (held_v) begin
        chk(word_valid && (word_data == held), "R9", "stalled word held",
            word_data, held);
        held_v = 0;
      end
      if (byte_valid && byte_ready) bi++;
      if (word_valid) begin
        if (word_to_video != e_vid) route_ok = 0;
        if (word_ready) begin
          if (wc < 16) got[wc] = word_data;
          wc++;
          last_fire = cyc;
        end else begin
          held = word_data;
          held_v = 1;
        end
      end
      if (done) begin
        done_cyc = cyc;
        d_err = done_err; d_vid = done_video; d_bta = done_bta;
        d_hs = done_hs; d_cnt = done_count;
        break;
      end
      @(negedge clk);
    end
    byte_valid = 1'b0;
    word_ready = 1'b0;

    chk(done_cyc >= 0, "R9", $sformatf("done seen len=%0d", len), 32'(done_cyc), 0);
    chk(wc == e_n, "R3", $sformatf("word count len=%0d", len), 32'(wc), 32'(e_n));
    for (int k = 0; k < e_n && k < wc && k < 16; k++) begin
      logic [31:0] ew = exp_word(k, len, vc, dt);
      chk(got[k] == ew, (k == 0) ? "R1 R2" : "R3",
          $sformatf("word %0d len=%0d", k, len), got[k], ew);
    end
    chk(bi == (e_err ? 0 : len), "R5", $sformatf("bytes consumed len=%0d", len),
        32'(bi), 32'(e_err ? 0 : len));
    chk(d_err == e_err, "R5", $sformatf("done_err len=%0d", len), 32'(d_err), 32'(e_err));
    if (!e_err) begin
      chk(d_vid == e_vid, "R4", $sformatf("done_video len=%0d", len), 32'(d_vid), 32'(e_vid));
      chk(route_ok, "R4", $sformatf("word_to_video len=%0d", len), 32'(route_ok), 1);
      chk(d_hs == !lp, "R8", $sformatf("done_hs len=%0d", len), 32'(d_hs), 32'(!lp));
      chk(done_cyc == last_fire + 1, "R9", $sformatf("done timing len=%0d", len),
          32'(done_cyc), 32'(last_fire + 1));
    end else begin
      chk(done_cyc == 0, "R5", $sformatf("reject done timing len=%0d", len),
          32'(done_cyc), 0);
    end
    chk(d_bta == e_bta, "R6", $sformatf("done_bta len=%0d", len), 32'(d_bta), 32'(e_bta));
    chk(32'(d_cnt) == 32'(e_cnt), "R7", $sformatf("done_count len=%0d", len),
        32'(d_cnt), 32'(e_cnt));
    @(negedge clk);
    #1;
    chk(!done && cmd_ready, "R9", "done single pulse", {30'h0, done, cmd_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready && !word_valid && !byte_ready && !done, "R10", "reset state",
        {28'h0, cmd_ready, word_valid, byte_ready, done}, 32'h8);
    rst_n = 1'b1;
    for (int len = 0; len <= VL + 3; len++) run_case(len);
    run_case(2 * VL + 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule